// File: doc/BRIEF.md
# Condition Flags and Branch Enable Unit

This unit keeps the three sign flags (negative, zero, positive) that describe the last value written to a destination register. It also keeps the registered branch-enable bit that a microcoded sequencer tests. When the flag strobe is high, the unit classifies the 16-bit value on the internal bus and records exactly one flag.

When the branch strobe is high, the unit latches an AND-OR of the three condition bits of the instruction against the stored flags. This is done during decode, so a later branch state can test the result without waiting for flag logic.

The same unit also steers register specifiers for the register file. The destination number comes from the instruction or is forced to the link register, register 7. The first-source number comes from either of two instruction fields.

Top module: `ccb_unit`

## Requirements
- R1: After reset the stored flags are negative=0, zero=1, positive=0 and `branchEn` is 0. A branch evaluation with condition bits `instr[11:9]` = 3'b010 then gives 1; any mask without bit 10 gives 0.
- R2: On a rising clock edge with `ldFlags` high and `busVal[15]` = 1, only the negative flag becomes set.
- R3: On a rising clock edge with `ldFlags` high and `busVal` equal to zero, only the zero flag becomes set.
- R4: On a rising clock edge with `ldFlags` high and `busVal` nonzero with bit 15 clear, only the positive flag becomes set.
- R5: On a rising clock edge with `ldBranch` high, `branchEn` becomes `(instr[11] & negative) | (instr[10] & zero) | (instr[9] & positive)`.
- R6: While `ldBranch` is low, `branchEn` keeps its value whatever `instr`, `busVal` or the flags do.
- R7: While `ldFlags` is low, the stored flags keep their value whatever `busVal` does.
- R8: When `ldFlags` and `ldBranch` are both high on the same edge, `branchEn` is computed from the flags held before that edge. The new flags take effect from the next evaluation.
- R9: `dstReg` is `instr[11:9]` when `dstLinkSel` is 0 and 3'b111 when it is 1, combinationally.
- R10: `src1Reg` is `instr[11:9]` when `src1LowSel` is 0 and `instr[8:6]` when it is 1, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busVal | input | 16 | Value being written to a destination register |
| instr | input | 16 | Current instruction word |
| ldFlags | input | 1 | Strobe: record flags from `busVal` |
| ldBranch | input | 1 | Strobe: latch branch enable |
| dstLinkSel | input | 1 | 1 forces destination to register 7 |
| src1LowSel | input | 1 | 1 takes source 1 from `instr[8:6]` |
| branchEn | output | 1 | Registered branch-enable bit |
| dstReg | output | 3 | Destination register number |
| src1Reg | output | 3 | Source-1 register number |

## Verification
A flag update and a branch evaluation can land on the same clock edge. This is the case where a stale-versus-fresh mix-up would hide. The bench first loads one flag, then raises both strobes together with a bus value of the opposite class and a condition mask that selects only the old flag. It expects `branchEn` to be 1, and the follow-up evaluations must see only the new flag. The reverse pairing (old zero, new positive, mask selecting positive) must give 0.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
  localparam int FLAG_CNT = 3;
  localparam int FLAG_P   = 0;
  localparam int FLAG_Z   = 1;
  localparam int FLAG_N   = 2;

  typedef logic [FLAG_CNT-1:0] flagVec_t;

  localparam flagVec_t FLAGS_RESET = flagVec_t'(1 << FLAG_Z);

  typedef struct packed {
    logic flagWr;
    logic benWr;
    logic dstLink;
    logic srcAlt;
  } ccbStrobe_t;
endpackage

// File: rtl/ccb_ctrl.sv
module ccb_ctrl
  import ccb_pkg::*;
(
  input  logic       ldFlags,
  input  logic       ldBranch,
  input  logic       dstLinkSel,
  input  logic       src1LowSel,
  output ccbStrobe_t strobe
);
  always_comb begin
    strobe         = '0;
    strobe.flagWr  = ldFlags;
    strobe.benWr   = ldBranch;
    strobe.dstLink = dstLinkSel;
    strobe.srcAlt  = src1LowSel;
  end
endmodule

// File: rtl/ccb_datapath.sv
module ccb_datapath
  import ccb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IR_W     = 16,
  parameter int REG_W    = 3,
  parameter int COND_LSB = 9,
  parameter int DST_LSB  = 9,
  parameter int SRCB_LSB = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busVal,
  input  logic [IR_W-1:0]   instr,
  input  ccbStrobe_t        strobe,
  output flagVec_t          flagQ,
  output logic              benQ,
  output logic [REG_W-1:0]  dstReg,
  output logic [REG_W-1:0]  src1Reg
);
  localparam logic [REG_W-1:0] LINK_REG = '1;
  localparam int SIGN_BIT = DATA_W - 1;

  flagVec_t flagD;
  flagVec_t condMask;
  flagVec_t benTerm;
  logic     benD;
  logic     unusedInstrBits;

  assign unusedInstrBits = ^instr;

  // flag classification of the bus value
  always_comb begin
    flagD = '0;
    if (busVal[SIGN_BIT])     flagD[FLAG_N] = 1'b1;
    else if (busVal == '0)    flagD[FLAG_Z] = 1'b1;
    else                      flagD[FLAG_P] = 1'b1;
  end

  // condition bits are ordered P (lsb), Z, N to match the flag vector
  assign condMask = instr[COND_LSB +: FLAG_CNT];

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_CNT; gi++) begin : gBenTerm
      assign benTerm[gi] = condMask[gi] & flagQ[gi];
    end
  endgenerate

  assign benD = |benTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= FLAGS_RESET;
    end else if (strobe.flagWr) begin
      flagQ <= flagD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      benQ <= 1'b0;
    end else if (strobe.benWr) begin
      benQ <= benD;
    end
  end

  // register specifier steering
  always_comb begin
    if (strobe.dstLink) dstReg = LINK_REG;
    else                dstReg = instr[DST_LSB +: REG_W];
  end

  always_comb begin
    if (strobe.srcAlt) src1Reg = instr[SRCB_LSB +: REG_W];
    else               src1Reg = instr[DST_LSB +: REG_W];
  end
endmodule

// File: rtl/ccb_unit.sv
module ccb_unit
  import ccb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IR_W     = 16,
  parameter int REG_W    = 3,
  parameter int COND_LSB = 9,
  parameter int DST_LSB  = 9,
  parameter int SRCB_LSB = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busVal,
  input  logic [IR_W-1:0]   instr,
  input  logic              ldFlags,
  input  logic              ldBranch,
  input  logic              dstLinkSel,
  input  logic              src1LowSel,
  output logic              branchEn,
  output logic [REG_W-1:0]  dstReg,
  output logic [REG_W-1:0]  src1Reg
);
  ccbStrobe_t strobe;
  flagVec_t   flagQ;

  ccb_ctrl uCtrl (
    .ldFlags    (ldFlags),
    .ldBranch   (ldBranch),
    .dstLinkSel (dstLinkSel),
    .src1LowSel (src1LowSel),
    .strobe     (strobe)
  );

  ccb_datapath #(
    .DATA_W   (DATA_W),
    .IR_W     (IR_W),
    .REG_W    (REG_W),
    .COND_LSB (COND_LSB),
    .DST_LSB  (DST_LSB),
    .SRCB_LSB (SRCB_LSB)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .busVal  (busVal),
    .instr   (instr),
    .strobe  (strobe),
    .flagQ   (flagQ),
    .benQ    (branchEn),
    .dstReg  (dstReg),
    .src1Reg (src1Reg)
  );
endmodule

// File: rtl/ccb_checker.sv
module ccb_checker
  import ccb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IR_W     = 16,
  parameter int REG_W    = 3,
  parameter int COND_LSB = 9,
  parameter int DST_LSB  = 9,
  parameter int SRCB_LSB = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] busVal,
  input logic [IR_W-1:0]   instr,
  input logic              ldFlags,
  input logic              ldBranch,
  input logic              dstLinkSel,
  input logic              src1LowSel,
  input logic              branchEn,
  input logic [REG_W-1:0]  dstReg,
  input logic [REG_W-1:0]  src1Reg,
  input flagVec_t          flagVec
);
  a_r2_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    $countones(flagVec) == 1);

  a_r2_negative: assert property (@(posedge clk) disable iff (!rstN)
    (ldFlags && busVal[DATA_W-1]) |=> flagVec[FLAG_N]);

  a_r3_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ldFlags && busVal == '0) |=> flagVec[FLAG_Z]);

  a_r4_positive: assert property (@(posedge clk) disable iff (!rstN)
    (ldFlags && !busVal[DATA_W-1] && busVal != '0) |=> flagVec[FLAG_P]);

  a_r5_r8_ben_eval: assert property (@(posedge clk) disable iff (!rstN)
    ldBranch |=> branchEn == |($past(instr[COND_LSB +: FLAG_CNT]) & $past(flagVec)));

  a_r6_ben_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ldBranch |=> $stable(branchEn));

  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ldFlags |=> $stable(flagVec));

  a_r9_link_dst: assert property (@(posedge clk) disable iff (!rstN)
    dstLinkSel |-> dstReg == '1);

  a_r10_src_alt: assert property (@(posedge clk) disable iff (!rstN)
    src1LowSel |-> src1Reg == instr[SRCB_LSB +: REG_W]);
endmodule

bind ccb_unit ccb_checker #(
  .DATA_W   (DATA_W),
  .IR_W     (IR_W),
  .REG_W    (REG_W),
  .COND_LSB (COND_LSB),
  .DST_LSB  (DST_LSB),
  .SRCB_LSB (SRCB_LSB)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busVal     (busVal),
  .instr      (instr),
  .ldFlags    (ldFlags),
  .ldBranch   (ldBranch),
  .dstLinkSel (dstLinkSel),
  .src1LowSel (src1LowSel),
  .branchEn   (branchEn),
  .dstReg     (dstReg),
  .src1Reg    (src1Reg),
  .flagVec    (flagQ)
);

// File: tb/sim_ccb_unit.sv
module sim_ccb_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] busVal;
  logic [15:0] instr;
  logic        ldFlags, ldBranch, dstLinkSel, src1LowSel;
  logic        branchEn;
  logic [2:0]  dstReg, src1Reg;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  logic [2:0] expFlags;   // {neg, zero, pos}
  logic       expBen;

  always #5 clk = ~clk;

  ccb_unit u0 (
    .clk(clk), .rstN(rstN), .busVal(busVal), .instr(instr),
    .ldFlags(ldFlags), .ldBranch(ldBranch), .dstLinkSel(dstLinkSel),
    .src1LowSel(src1LowSel), .branchEn(branchEn), .dstReg(dstReg),
    .src1Reg(src1Reg)
  );

  function automatic logic [2:0] flagsOf(logic [15:0] v);
    if ($signed(v) < 0) return 3'b100;
    else if (v == 16'd0) return 3'b010;
    else return 3'b001;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic loadFlags(logic [15:0] v);
    ldFlags = 1'b1;
    busVal  = v;
    cycle();
    ldFlags = 1'b0;
    expFlags = flagsOf(v);
  endtask

  task automatic probe(logic [2:0] mask, string req);
    instr    = {4'h5, mask, 9'h0B6};
    ldBranch = 1'b1;
    cycle();
    ldBranch = 1'b0;
    expBen   = |(mask & expFlags);
    check(req, {15'd0, branchEn}, {15'd0, expBen});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [10];
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000,
             16'hFFFF, 16'h00FF, 16'h8001, 16'h4000, 16'h0000};
    rstN = 1'b0; busVal = '0; instr = '0;
    ldFlags = 1'b0; ldBranch = 1'b0; dstLinkSel = 1'b0; src1LowSel = 1'b0;
    repeat (3) cycle();
    check("R1 reset ben", {15'd0, branchEn}, 16'd0);
    rstN = 1'b1;
    cycle();
    expFlags = 3'b010;
    // R1: reset flags seen through every condition mask
    for (int m = 0; m < 8; m++) probe(3'(m), "R1");

    // R2 R3 R4 R5: each value class against all masks
    for (int i = 0; i < 10; i++) begin
      loadFlags(vals[i]);
      for (int m = 0; m < 8; m++) begin
        if (vals[i][15])        probe(3'(m), "R2 R5");
        else if (vals[i] == 0)  probe(3'(m), "R3 R5");
        else                    probe(3'(m), "R4 R5");
      end
    end

    // R6: branchEn holds with ldBranch low
    loadFlags(16'h0003);
    probe(3'b001, "R6 setup");
    for (int m = 0; m < 8; m++) begin
      instr = {4'hF, 3'(m), 9'h1FF};
      cycle();
      check("R6", {15'd0, branchEn}, 16'd1);
    end
    loadFlags(16'h0000);
    check("R6 after flag load", {15'd0, branchEn}, 16'd1);

    // R7: flags hold with ldFlags low
    busVal = 16'h8000; cycle();
    busVal = 16'h0042; cycle();
    for (int m = 0; m < 8; m++) probe(3'(m), "R7");

    // R8: both strobes on one edge, old negative vs new zero
    loadFlags(16'h9000);
    instr = {4'h0, 3'b100, 9'h000};
    busVal = 16'h0000; ldFlags = 1'b1; ldBranch = 1'b1;
    cycle();
    ldFlags = 1'b0; ldBranch = 1'b0;
    check("R8 old flag used", {15'd0, branchEn}, 16'd1);
    expFlags = 3'b010;
    probe(3'b010, "R8 new zero");
    probe(3'b100, "R8 negative gone");
    // R8: old zero vs new positive
    instr = {4'h0, 3'b001, 9'h000};
    busVal = 16'h0005; ldFlags = 1'b1; ldBranch = 1'b1;
    cycle();
    ldFlags = 1'b0; ldBranch = 1'b0;
    check("R8 stale positive", {15'd0, branchEn}, 16'd0);
    expFlags = 3'b001;
    probe(3'b001, "R8 new positive");

    // R9 R10: register specifier sweep
    for (int f = 0; f < 64; f++) begin
      for (int s = 0; s < 2; s++) begin
        instr = {4'hA, 6'(f), 6'h2A};
        dstLinkSel = s[0];
        src1LowSel = s[0];
        #1;
        check("R9", {13'd0, dstReg}, s ? 16'd7 : 16'(f / 8));
        check("R10", {13'd0, src1Reg}, s ? 16'(f % 8) : 16'(f / 8));
        dstLinkSel = ~s[0];
        src1LowSel = ~s[0];
        #1;
        check("R9 mixed", {13'd0, dstReg}, !s ? 16'd7 : 16'(f / 8));
        check("R10 mixed", {13'd0, src1Reg}, !s ? 16'(f % 8) : 16'(f / 8));
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule